// File: doc/BRIEF.md
# Programmable Interrupt Controller Command Port

This block collects up to eight interrupt request lines and exposes them through a small two-address register port. Software brings it into service by writing an initialization word sequence. The first word is recognised from its data alone, and one or two further words follow at the high address. Once initialised, writes at the high address set the request mask. Writes at the low address are decoded as operation words. One kind carries a specific end-of-interrupt. The other selects which internal register the low address reads back.

Internally the block keeps a request register, an in-service register and a mask register. The `pend` output tells a processor-side agent that some unmasked request is waiting. A one-cycle `take` strobe accepts the waiting request with the lowest index: its bit moves from the request register to the in-service register. A later specific end-of-interrupt command retires it. Each input can be captured on a rising edge or while its level is high. The choice comes from the first initialization word.

Top module: `irq_cmd_ctrl`

## Requirements
- R1: After reset the block awaits the first initialization word, `pend` is 0, request, in-service and mask registers are all 0, and the low-address read select points at the request register.
- R2: A write with `a0`=0 and data bit 4 set is taken as the first initialization word in any state. It stores data bit 0 (fourth word needed), bit 1 (single controller) and bit 3 (level capture), moves to await the second word, clears the mask and in-service registers, and sets the read select back to the request register.
- R3: Each further initialization word is written with `a0`=1. After the second word the block awaits a third if bit 1 was 0, else a fourth if bit 0 was 1, else it becomes ready. After the third word it awaits a fourth if bit 0 was 1, else it becomes ready. After the fourth word it becomes ready.
- R4: Writes that match no word expected in the current state have no effect. These are `a0`=1 while awaiting the first word, and `a0`=0 with bit 4 clear during initialization.
- R5: When the block is ready, a write with `a0`=1 loads the mask register. A read with `a0`=1 returns the mask register in every state.
- R6: When ready, a write with `a0`=0 and bits 4:3 = 00 is an end-of-interrupt command with level in bits 2:0, EOI flag in bit 5, SL in bit 6 and R in bit 7. Only EOI=1, SL=1, R=0 clears the in-service bit named by the level. Every other combination leaves the in-service register unchanged.
- R7: When ready, a write with `a0`=0 and bits 4:3 = 01 stores bits 1:0 as the read select. A read at `a0`=0 returns the request register for select 10, the in-service register for 11, and 0 for 00 or 01.
- R8: With level capture off, a rising edge on `irq[n]` sets request bit n. With it on, request bit n is set in every cycle that `irq[n]` is high.
- R9: `pend` is 1 exactly when the request register ANDed with the inverted mask register is nonzero.
- R10: A `take` strobe moves the lowest-index unmasked pending request from the request register to the in-service register. It changes nothing when no unmasked request is pending. A capture in the same cycle wins over the clear.
- R11: `rdata` is registered: it shows the selected value on the clock edge that samples `rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| a0 | input | 1 | Register address bit |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, one cycle per read |
| wd | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| irq | input | N_IRQ | Interrupt request lines |
| take | input | 1 | Accept the highest-priority pending request |
| pend | output | 1 | Unmasked request waiting |

## Verification
A write, an `irq` change or a `take` alters the registers on the first rising edge that samples it. `pend` follows on that same edge, because it is formed combinationally from the registers. A read samples the registers as they stand before its own edge and delivers them on `rdata` at that edge. So the value reflecting a stimulus appears one read later. The bench drives every input on the falling edge, holds it for exactly one rising edge, and samples outputs on the following falling edge. A cycle-exact reference model, updated on the rising edge from the same driven inputs, is compared against `pend` and `rdata` on every falling edge during a long pseudo-random phase.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;

   typedef enum logic [2:0] {
      SQ_WAIT1 = 3'd0,
      SQ_WAIT2 = 3'd1,
      SQ_WAIT3 = 3'd2,
      SQ_WAIT4 = 3'd3,
      SQ_RUN   = 3'd4
   } seq_state_t;

   // initialization word bit positions
   localparam int unsigned B_NEED4  = 0;
   localparam int unsigned B_SINGLE = 1;
   localparam int unsigned B_LEVEL  = 3;
   localparam int unsigned B_INIT   = 4;
   // operation word bit positions
   localparam int unsigned B_KIND   = 3;
   localparam int unsigned B_EOI    = 5;
   localparam int unsigned B_SL     = 6;
   localparam int unsigned B_ROT    = 7;

   localparam logic [1:0] SEL_REQ  = 2'b10;
   localparam logic [1:0] SEL_SERV = 2'b11;

   localparam int unsigned CW_W  = 8;
   localparam int unsigned LVL_W = 3;

endpackage

// File: rtl/irq_seq.sv
module irq_seq
   import irq_cmd_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             wr,
   input  logic             a0,
   input  logic [CW_W-1:0]  cw,
   output logic             run,
   output logic             lvl_mode,
   output logic             init_hit,
   output logic             mask_we,
   output logic             eoi_hit,
   output logic [LVL_W-1:0] eoi_lvl,
   output logic [1:0]       rd_sel
);

   seq_state_t state, state_nx;
   logic       need4, single;
   logic       op_hit, op_eoi, op_sel;

   always_comb begin
      init_hit = wr & ~a0 & cw[B_INIT];
      run      = (state == SQ_RUN);
      op_hit   = wr & ~a0 & ~cw[B_INIT] & run;
      op_eoi   = op_hit & ~cw[B_KIND];
      op_sel   = op_hit & cw[B_KIND];
      eoi_hit  = op_eoi & cw[B_EOI] & cw[B_SL] & ~cw[B_ROT];
      eoi_lvl  = cw[LVL_W-1:0];
      mask_we  = wr & a0 & run;
   end

   always_comb begin
      state_nx = state;
      if (wr && a0) begin
         unique case (state)
            SQ_WAIT2: state_nx = !single ? SQ_WAIT3 : (need4 ? SQ_WAIT4 : SQ_RUN);
            SQ_WAIT3: state_nx = need4 ? SQ_WAIT4 : SQ_RUN;
            SQ_WAIT4: state_nx = SQ_RUN;
            default:  state_nx = state;
         endcase
      end
      if (init_hit) state_nx = SQ_WAIT2;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state    <= SQ_WAIT1;
         need4    <= 1'b0;
         single   <= 1'b0;
         lvl_mode <= 1'b0;
         rd_sel   <= SEL_REQ;
      end else begin
         state <= state_nx;
         if (init_hit) begin
            need4    <= cw[B_NEED4];
            single   <= cw[B_SINGLE];
            lvl_mode <= cw[B_LEVEL];
            rd_sel   <= SEL_REQ;
         end else if (op_sel) begin
            rd_sel   <= cw[1:0];
         end
      end
   end

   AST_INIT_RESTART: assert property (@(posedge clk) disable iff (rst)
      init_hit |=> (state == SQ_WAIT2 && rd_sel == SEL_REQ)); // R2
   AST_RUN_STAYS: assert property (@(posedge clk) disable iff (rst)
      (run && !init_hit) |=> run); // R3
   AST_WAIT1_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_WAIT1 && !init_hit) |=> (state == SQ_WAIT1)); // R4

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] cand,
   output logic [N-1:0] win
);

   always_comb begin
      win = cand & (~cand + N'(1));
   end

   always_comb begin
      AST_PICK_ONEHOT: assert ($onehot0(win)); // R10
      AST_PICK_LIVE: assert ((cand == '0) || ((win & cand) == win && win != '0)); // R10
   end

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
   parameter int unsigned N           = 8,
   parameter int unsigned SYNC_STAGES = 0,
   parameter int unsigned LVL_W       = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N-1:0]     req,
   input  logic             lvl_mode,
   input  logic             take,
   input  logic             init_hit,
   input  logic             mask_we,
   input  logic [N-1:0]     mask_d,
   input  logic             eoi_hit,
   input  logic [LVL_W-1:0] eoi_lvl,
   output logic [N-1:0]     irr,
   output logic [N-1:0]     isr,
   output logic [N-1:0]     imr,
   output logic             pend
);

   logic [N-1:0] req_s, req_q, set_v, win, take_v, eoi_v, live;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign req_s = req;
   end else begin : g_sync
      logic [N-1:0] stg [SYNC_STAGES];
      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            for (int s = 0; s < int'(SYNC_STAGES); s++) stg[s] <= '0;
         end else begin
            stg[0] <= req;
            for (int s = 1; s < int'(SYNC_STAGES); s++) stg[s] <= stg[s-1];
         end
      end
      assign req_s = stg[SYNC_STAGES-1];
   end

   for (genvar k = 0; k < int'(N); k++) begin : g_line
      always_ff @(posedge clk or posedge rst) begin
         if (rst) req_q[k] <= 1'b0;
         else     req_q[k] <= req_s[k];
      end
      assign set_v[k] = req_s[k] & (lvl_mode | ~req_q[k]);
      assign eoi_v[k] = eoi_hit & (eoi_lvl == LVL_W'(k));
   end

   assign live = irr & ~imr;

   irq_pick #(.N(N)) u_pick (
      .cand (live),
      .win  (win)
   );

   assign take_v = take ? win : '0;
   assign pend   = |live;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         irr <= '0;
         isr <= '0;
         imr <= '0;
      end else begin
         irr <= (irr & ~take_v) | set_v;
         isr <= ((init_hit ? '0 : isr) & ~eoi_v) | take_v;
         if (init_hit)     imr <= '0;
         else if (mask_we) imr <= mask_d;
      end
   end

   AST_REQ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (set_v != '0) |=> ((irr & $past(set_v)) == $past(set_v))); // R8
   AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (eoi_v != '0 && take_v == '0) |=> ((isr & $past(eoi_v)) == '0)); // R6
   AST_TAKE_MOVE: assert property (@(posedge clk) disable iff (rst)
      (take_v != '0) |=> ((isr & $past(take_v)) == $past(take_v))); // R10
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
      (mask_we && !init_hit) |=> (imr == $past(mask_d))); // R5
   AST_PEND_IDLE: assert property (@(posedge clk) disable iff (rst)
      (init_hit && !lvl_mode && req_s == '0 && irr == '0) |=> !pend); // R9

endmodule

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl
   import irq_cmd_pkg::*;
#(
   parameter int unsigned N_IRQ       = 8,
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             a0,
   input  logic             wr,
   input  logic             rd,
   input  logic [DW-1:0]    wd,
   output logic [DW-1:0]    rdata,
   input  logic [N_IRQ-1:0] irq,
   input  logic             take,
   output logic             pend
);

   if (N_IRQ < 2 || N_IRQ > (1 << LVL_W)) begin : g_bad_n
      $error("irq_cmd_ctrl: N_IRQ out of range");
   end
   if (DW != CW_W) begin : g_bad_dw
      $error("irq_cmd_ctrl: DW must match the command word width");
   end
   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("irq_cmd_ctrl: SYNC_STAGES too deep");
   end

   logic             run, lvl_mode, init_hit, mask_we, eoi_hit;
   logic [LVL_W-1:0] eoi_lvl;
   logic [1:0]       rd_sel;
   logic [N_IRQ-1:0] irr, isr, imr;
   logic [DW-1:0]    ext_irr, ext_isr, ext_imr, rd_nx;

   irq_seq u_seq (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr),
      .a0       (a0),
      .cw       (wd[CW_W-1:0]),
      .run      (run),
      .lvl_mode (lvl_mode),
      .init_hit (init_hit),
      .mask_we  (mask_we),
      .eoi_hit  (eoi_hit),
      .eoi_lvl  (eoi_lvl),
      .rd_sel   (rd_sel)
   );

   irq_bank #(.N(N_IRQ), .SYNC_STAGES(SYNC_STAGES), .LVL_W(LVL_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .req      (irq),
      .lvl_mode (lvl_mode),
      .take     (take),
      .init_hit (init_hit),
      .mask_we  (mask_we),
      .mask_d   (wd[N_IRQ-1:0]),
      .eoi_hit  (eoi_hit),
      .eoi_lvl  (eoi_lvl),
      .irr      (irr),
      .isr      (isr),
      .imr      (imr),
      .pend     (pend)
   );

   always_comb begin
      ext_irr = '0;
      ext_isr = '0;
      ext_imr = '0;
      ext_irr[N_IRQ-1:0] = irr;
      ext_isr[N_IRQ-1:0] = isr;
      ext_imr[N_IRQ-1:0] = imr;
      if (a0)                    rd_nx = ext_imr;
      else if (rd_sel == SEL_REQ)  rd_nx = ext_irr;
      else if (rd_sel == SEL_SERV) rd_nx = ext_isr;
      else                       rd_nx = '0;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     rdata <= '0;
      else if (rd) rdata <= rd_nx;
   end

   AST_READ_MASK: assert property (@(posedge clk) disable iff (rst)
      (rd && a0) |=> (rdata == $past(ext_imr))); // R5
   AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
      !rd |=> $stable(rdata)); // R11
   AST_READ_NONE: assert property (@(posedge clk) disable iff (rst)
      (rd && !a0 && !rd_sel[1]) |=> (rdata == '0)); // R7

endmodule

// File: tb/sim_irq_cmd_ctrl.sv
module sim_irq_cmd_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       a0 = 1'b0, wr = 1'b0, rd = 1'b0, take = 1'b0;
   logic [7:0] wd = 8'h00, irq = 8'h00;
   logic [7:0] rdata;
   logic       pend;

   int unsigned n_chk = 0, n_err = 0;
   bit          done = 1'b0;
   bit          cmp_on = 1'b0;

   always #4 clk = ~clk;

   irq_cmd_ctrl #(.N_IRQ(8), .DW(8), .SYNC_STAGES(0)) u0 (
      .clk(clk), .rst(rst), .a0(a0), .wr(wr), .rd(rd), .wd(wd),
      .rdata(rdata), .irq(irq), .take(take), .pend(pend)
   );

   // reference model, cycle exact, from the requirements
   logic [7:0] m_irr, m_isr, m_imr, m_rq, m_rd, m_set, m_av, m_tk, m_eoi;
   logic [1:0] m_sel;
   int         m_st;
   logic       m_sg, m_ic, m_lv, m_init;

   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_irr = 0; m_isr = 0; m_imr = 0; m_rq = 0; m_rd = 0;
         m_sel = 2'b10; m_st = 0; m_sg = 0; m_ic = 0; m_lv = 0;
      end else begin
         m_set = m_lv ? irq : (irq & ~m_rq);
         m_rq  = irq;
         m_av  = m_irr & ~m_imr;
         m_tk  = 0;
         if (take) begin
            for (int k = 7; k >= 0; k--) if (m_av[k]) m_tk = 8'(1 << k);
         end
         if (rd) m_rd = a0 ? m_imr : (m_sel == 2'b10 ? m_irr : (m_sel == 2'b11 ? m_isr : 8'h00));
         m_eoi = 0; m_init = 0;
         if (wr) begin
            if (!a0 && wd[4]) m_init = 1;
            else if (!a0) begin
               if (m_st == 4 && !wd[3] && wd[7:5] == 3'b011) m_eoi = 8'(1 << wd[2:0]);
               else if (m_st == 4 && wd[3]) m_sel = wd[1:0];
            end else begin
               case (m_st)
                  1: m_st = !m_sg ? 2 : (m_ic ? 3 : 4);
                  2: m_st = m_ic ? 3 : 4;
                  3: m_st = 4;
                  4: m_imr = wd;
                  default: ;
               endcase
            end
         end
         m_irr = (m_irr & ~m_tk) | m_set;
         m_isr = ((m_init ? 8'h00 : m_isr) & ~m_eoi) | m_tk;
         if (m_init) begin
            m_st = 1; m_sg = wd[1]; m_ic = wd[0]; m_lv = wd[3];
            m_imr = 0; m_sel = 2'b10;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic a, input logic [7:0] d);
      a0 = a; wd = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic do_rd(input logic a, output logic [7:0] v);
      a0 = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      v = rdata;
   endtask

   task automatic do_take();
      take = 1'b1;
      @(negedge clk);
      take = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   // compare against the model on every falling edge while enabled
   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         chk("R9 pend vs model", {31'd0, pend}, {31'd0, |(m_irr & ~m_imr)});
         chk("R11 rdata vs model", {24'd0, rdata}, {24'd0, m_rd});
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL R11 watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v, lfsr;
      int         nw;
      do_reset();

      // R1 reset state
      chk("R1 pend after reset", {31'd0, pend}, 0);
      do_rd(1'b1, v); chk("R1 mask after reset", {24'd0, v}, 0);
      do_rd(1'b0, v); chk("R1 request read after reset", {24'd0, v}, 0);

      // R4 mask write while awaiting the first word
      do_wr(1'b1, 8'hFF);
      do_rd(1'b1, v); chk("R4 mask write before init ignored", {24'd0, v}, 0);

      // R3 sequencing for every single/need4 combination
      for (int c = 0; c < 4; c++) begin
         nw = 1 + ((c & 2) ? 0 : 1) + ((c & 1) ? 1 : 0);
         do_wr(1'b0, 8'h10 | 8'(c));
         do_wr(1'b0, 8'h0B);                       // R4 ignored during init
         for (int i = 0; i < nw - 1; i++) do_wr(1'b1, 8'h77);
         do_rd(1'b1, v); chk("R3 mask not loaded before last init word", {24'd0, v}, 0);
         do_wr(1'b1, 8'h66);
         do_rd(1'b1, v); chk("R3 last init word not taken as mask", {24'd0, v}, 0);
         do_wr(1'b1, 8'h5A);
         do_rd(1'b1, v); chk("R5 mask loaded once ready", {24'd0, v}, 8'h5A);
      end
      // R2 restart clears mask
      do_wr(1'b0, 8'h12);
      do_rd(1'b1, v); chk("R2 mask cleared by first init word", {24'd0, v}, 0);
      do_wr(1'b1, 8'h00);                          // single, no fourth: ready

      // R8 edge capture, R9 pend vs every mask, R5 mask readback
      irq = 8'hFF;
      @(negedge clk);
      do_rd(1'b0, v); chk("R8 edge capture all lines", {24'd0, v}, 8'hFF);
      for (int m = 0; m < 256; m++) begin
         do_wr(1'b1, 8'(m));
         chk("R9 pend against mask", {31'd0, pend}, {31'd0, (m != 255)});
         do_rd(1'b1, v); chk("R5 mask readback", {24'd0, v}, m);
      end
      do_wr(1'b1, 8'h00);

      // R10 take order with edge capture (lines stay high)
      for (int k = 0; k < 8; k++) begin
         do_take();
         do_wr(1'b0, 8'h0A);
         do_rd(1'b0, v); chk("R10 R8 request after take", {24'd0, v}, 32'(8'(8'hFF << (k + 1))));
         do_wr(1'b0, 8'h0B);
         do_rd(1'b0, v); chk("R10 in-service after take", {24'd0, v}, 32'(8'((16'd1 << (k + 1)) - 1)));
      end
      chk("R9 pend with empty request", {31'd0, pend}, 0);

      // R6 end-of-interrupt decoding, select stays on in-service
      for (int c = 0; c < 8; c++) begin
         if (c == 3) continue;
         for (int l = 0; l < 8; l++) begin
            do_wr(1'b0, {3'(c), 2'b00, 3'(l)});
            do_rd(1'b0, v); chk("R6 non-specific combination no effect", {24'd0, v}, 8'hFF);
         end
      end
      for (int l = 0; l < 8; l++) begin
         do_wr(1'b0, {3'b011, 2'b00, 3'(l)});
         do_rd(1'b0, v); chk("R6 specific end clears level", {24'd0, v}, 32'(8'(8'hFF << (l + 1))));
      end

      // R7 unselected reads
      do_wr(1'b0, 8'h08);
      do_rd(1'b0, v); chk("R7 select 00 reads zero", {24'd0, v}, 0);
      do_wr(1'b0, 8'h09);
      do_rd(1'b0, v); chk("R7 select 01 reads zero", {24'd0, v}, 0);

      // R11 hold
      do_rd(1'b1, v);
      do_wr(1'b1, 8'h3C);
      @(negedge clk);
      chk("R11 rdata holds without read", {24'd0, rdata}, 0);

      // R8 level capture, R10 masked / none
      irq = 8'h00;
      do_reset();
      do_wr(1'b0, 8'h1A);                          // level, single, no fourth
      do_wr(1'b1, 8'h00);
      irq = 8'h04;
      @(negedge clk);
      do_wr(1'b1, 8'h04);
      do_take();
      do_wr(1'b0, 8'h0B);
      do_rd(1'b0, v); chk("R10 masked request not taken", {24'd0, v}, 0);
      chk("R9 pend low when masked", {31'd0, pend}, 0);
      do_wr(1'b1, 8'h00);
      do_take();
      do_rd(1'b0, v); chk("R10 in-service after unmask take", {24'd0, v}, 8'h04);
      do_wr(1'b0, 8'h0A);
      do_rd(1'b0, v); chk("R8 level capture re-sets request", {24'd0, v}, 8'h04);
      irq = 8'h00;

      // pseudo-random sweep against the model
      do_reset();
      cmp_on = 1'b1;
      lfsr = 8'hA5;
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom();
         wr = 1'b0; rd = r[0]; take = (r[3:1] == 3'd0);
         a0 = r[4];
         if (r[7:5] == 3'd0) irq = irq ^ 8'(1 << r[10:8]);
         if (r[13:11] < 3'd3) begin
            wr = 1'b1;
            case (r[16:14])
               3'd0:    begin a0 = 1'b0; wd = 8'h10 | 8'(r[20:17]); end
               3'd1:    begin a0 = 1'b0; wd = {3'b011, 2'b00, r[19:17]}; end
               3'd2:    begin a0 = 1'b0; wd = {r[22:20], 2'b00, r[19:17]}; end
               3'd3:    begin a0 = 1'b0; wd = 8'h08 | 8'(r[18:17]); end
               default: begin a0 = 1'b1; wd = 8'(r[24:17]); end
            endcase
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5]};
         @(negedge clk);
      end
      wr = 1'b0; rd = 1'b0; take = 1'b0;
      @(negedge clk);
      cmp_on = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule